// File: doc/BRIEF.md
# Card Clock Mode Selector

This block chooses how the card clock of a storage-card host is derived from the source clock. Software or a sequencer presents a bus timing class (single data rate, dual data rate, or HS400 dual data rate), the wanted card frequency and the source frequency, then pulses a load strobe. The block captures the request and works out four results: a 2-bit mode code, an 8-bit divider field, a flag that switches the HS400 path to half the source rate, and the card frequency that the chosen setting produces.

The control is a two-state machine. In IDLE the block waits. On the transition ACCEPT (load seen in IDLE) it captures the inputs, clears the HS400 half-rate flag and moves to EVAL. On the transition COMMIT (always taken from EVAL) it writes all results at once, raises `done_o` for exactly one cycle and returns to IDLE. The block does not make the clock waveform itself.

Top module: `clk_mode_sel`

## Requirements
- R1: While `rst_n` is low, `mode_o`, `div_o`, `hs_ck_o`, `card_hz_o` and `done_o` are all zero.
- R2: A load seen in IDLE clears `hs_ck_o` on the next edge; on the edge after that the other results are written and `done_o` is high for exactly one cycle.
- R3: A load, or any change of the request inputs, while the block is in EVAL has no effect; the inputs captured at ACCEPT decide the result.
- R4: `timing_i` encodes 0 = single data rate, 1 = dual data rate, 2 = HS400; 3 is treated as single data rate. `mode_o` encodes 0 = single rate divided, 1 = single rate undivided, 2 = dual rate, 3 = HS400.
- R5: Single data rate with request ≥ source: mode 1, divider 0, card frequency equals the source frequency.
- R6: Single data rate with request < source: mode 0; with Q = floor(source/4), the divider n is the smallest integer ≥ 1 with n·request ≥ Q, capped at 255; card frequency = floor(Q/n).
- R7: Dual rate or HS400 (no half-rate override) with request ≥ Q: divider 0, card frequency Q.
- R8: Dual rate or HS400 with request < Q: k is the smallest integer with 2k·request ≥ Q, capped at 255; the divider field is k and the card frequency is floor(Q/(2k)).
- R9: HS400 with request ≥ floor(source/2): `hs_ck_o` = 1, mode 3, divider 0, card frequency floor(source/2).
- R10: A request of zero Hz in any divided case gives a divider of 255.
- R11: Outside the COMMIT cycle, `mode_o`, `div_o` and `card_hz_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Start a new selection |
| timing_i | input | 2 | Requested bus timing class |
| req_hz_i | input | 32 | Requested card frequency in Hz |
| src_hz_i | input | 32 | Source clock frequency in Hz |
| mode_o | output | 2 | Selected clock mode code |
| div_o | output | 8 | Divider field |
| hs_ck_o | output | 1 | HS400 half-source-rate flag |
| card_hz_o | output | 32 | Resulting card frequency in Hz |
| done_o | output | 1 | One-cycle pulse when results are written |

## Verification
Requests are chosen on both sides of each threshold: equal to the source and just below it for single rate, equal to a quarter of the source and below it for dual rate, and at half the source versus between a quarter and a half for HS400, so each pattern separates one branch from its neighbour. Divided requests that give odd quotients and exact quotients show whether the divider rounds up, while zero and one Hz requests drive the cap at 255. A tiny source below four Hz exercises the minimum divider of one, and an HS400 selection followed by a dual rate one shows that the half-rate flag is cleared. A load held for two cycles and inputs changed during EVAL check that only captured values count.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

    typedef enum logic [1:0] {
        TM_SDR = 2'd0,
        TM_DDR = 2'd1,
        TM_HS  = 2'd2,
        TM_RSV = 2'd3
    } timing_e;

    typedef enum logic [1:0] {
        MD_SDR_DIV  = 2'd0,
        MD_SDR_FULL = 2'd1,
        MD_DDR      = 2'd2,
        MD_HS       = 2'd3
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } sel_state_e;

endpackage

// File: rtl/clk_sdr_calc.sv
module clk_sdr_calc
    import clk_mode_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int DIV_W  = 8
) (
    input  logic [FREQ_W-1:0] req,
    input  logic [FREQ_W-1:0] src,
    output logic [1:0]        mode,
    output logic [DIV_W-1:0]  field,
    output logic [FREQ_W-1:0] card
);
    localparam int WW = FREQ_W + 2;
    localparam logic [WW-1:0] NMAX = WW'((2 ** DIV_W) - 1);

    logic [WW-1:0] quarter, r, s, n;

    always_comb begin
        quarter = {2'b00, src >> 2};
        r       = {2'b00, req};
        s       = {2'b00, src};
        n       = '0;
        field   = '0;
        card    = src;
        mode    = MD_SDR_FULL;
        if (r < s) begin
            mode = MD_SDR_DIV;
            if (req == '0) n = NMAX;
            else           n = (quarter + r - WW'(1)) / r;
            if (n == '0)   n = WW'(1);
            if (n > NMAX)  n = NMAX;
            field = n[DIV_W-1:0];
            card  = FREQ_W'(quarter / n);
        end
    end
endmodule

// File: rtl/clk_ddr_calc.sv
module clk_ddr_calc
    import clk_mode_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int DIV_W  = 8
) (
    input  logic              hs400,
    input  logic [FREQ_W-1:0] req,
    input  logic [FREQ_W-1:0] src,
    output logic [1:0]        mode,
    output logic [DIV_W-1:0]  field,
    output logic              hs_ck,
    output logic [FREQ_W-1:0] card
);
    localparam int WW = FREQ_W + 2;
    localparam logic [WW-1:0] KMAX = WW'((2 ** DIV_W) - 1);

    logic [WW-1:0] quarter, half, r, den, k;

    always_comb begin
        quarter = {2'b00, src >> 2};
        half    = {2'b00, src >> 1};
        r       = {2'b00, req};
        den     = r << 1;
        k       = '0;
        mode    = hs400 ? MD_HS : MD_DDR;
        hs_ck   = 1'b0;
        field   = '0;
        card    = FREQ_W'(quarter);
        if (hs400 && (r >= half)) begin
            hs_ck = 1'b1;
            card  = FREQ_W'(half);
        end else if (r < quarter) begin
            if (req == '0) k = KMAX;
            else           k = (quarter + den - WW'(1)) / den;
            if (k == '0)   k = WW'(1);
            if (k > KMAX)  k = KMAX;
            field = k[DIV_W-1:0];
            card  = FREQ_W'(quarter / (k << 1));
        end
    end
endmodule

// File: rtl/clk_mode_sel.sv
module clk_mode_sel
    import clk_mode_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [1:0]        timing_i,
    input  logic [FREQ_W-1:0] req_hz_i,
    input  logic [FREQ_W-1:0] src_hz_i,
    output logic [1:0]        mode_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              hs_ck_o,
    output logic [FREQ_W-1:0] card_hz_o,
    output logic              done_o
);
    sel_state_e state_q, state_d;

    logic [1:0]        tim_q;
    logic [FREQ_W-1:0] req_q, src_q;

    logic [1:0]        s_mode, d_mode;
    logic [DIV_W-1:0]  s_field, d_field;
    logic [FREQ_W-1:0] s_card, d_card;
    logic              d_hs;
    logic              use_ddr, is_hs;

    assign is_hs   = (tim_q == TM_HS);
    assign use_ddr = (tim_q == TM_DDR) || is_hs;

    clk_sdr_calc #(.FREQ_W(FREQ_W), .DIV_W(DIV_W)) u_sdr (
        .req(req_q), .src(src_q),
        .mode(s_mode), .field(s_field), .card(s_card)
    );

    clk_ddr_calc #(.FREQ_W(FREQ_W), .DIV_W(DIV_W)) u_ddr (
        .hs400(is_hs), .req(req_q), .src(src_q),
        .mode(d_mode), .field(d_field), .hs_ck(d_hs), .card(d_card)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_i) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q     <= '0;
            req_q     <= '0;
            src_q     <= '0;
            mode_o    <= '0;
            div_o     <= '0;
            hs_ck_o   <= 1'b0;
            card_hz_o <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (load_i) begin
                        tim_q   <= timing_i;
                        req_q   <= req_hz_i;
                        src_q   <= src_hz_i;
                        hs_ck_o <= 1'b0;
                    end
                end
                ST_EVAL: begin
                    done_o <= 1'b1;
                    if (use_ddr) begin
                        mode_o    <= d_mode;
                        div_o     <= d_field;
                        hs_ck_o   <= d_hs;
                        card_hz_o <= d_card;
                    end else begin
                        mode_o    <= s_mode;
                        div_o     <= s_field;
                        hs_ck_o   <= 1'b0;
                        card_hz_o <= s_card;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/clk_mode_sel_chk.sv
module clk_mode_sel_chk #(
    parameter int FREQ_W = 32,
    parameter int DIV_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_o,
    input logic [DIV_W-1:0]  div_o,
    input logic              hs_ck_o,
    input logic [FREQ_W-1:0] card_hz_o,
    input logic              done_o
);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    hs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_ck_o) |-> done_o);

    // R9
    hs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ck_o |-> (mode_o == 2'd3) && (div_o == '0));

    // R5
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1) |-> (div_o == '0));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(mode_o) && $stable(div_o) && $stable(card_hz_o)));
endmodule

bind clk_mode_sel clk_mode_sel_chk #(.FREQ_W(FREQ_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .div_o(div_o),
    .hs_ck_o(hs_ck_o), .card_hz_o(card_hz_o), .done_o(done_o)
);

// File: tb/sim_clk_mode_sel.sv
module sim_clk_mode_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [1:0]  timing_i = '0;
    logic [31:0] req_hz_i = '0;
    logic [31:0] src_hz_i = '0;
    logic [1:0]  mode_o;
    logic [7:0]  div_o;
    logic        hs_ck_o;
    logic [31:0] card_hz_o;
    logic        done_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string tag = "R1";

    // behavioural reference state
    bit             m_busy;
    int unsigned    m_tim;
    longint unsigned m_req, m_src;
    int unsigned    m_mode, m_div;
    bit             m_hs, m_done;
    longint unsigned m_card;

    always #5 clk = ~clk;

    clk_mode_sel u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .timing_i(timing_i),
        .req_hz_i(req_hz_i), .src_hz_i(src_hz_i), .mode_o(mode_o),
        .div_o(div_o), .hs_ck_o(hs_ck_o), .card_hz_o(card_hz_o), .done_o(done_o)
    );

    task automatic predict(input int unsigned t, input longint unsigned rq,
                           input longint unsigned sr);
        longint unsigned q, k;
        q = sr / 4;
        m_hs = 0;
        if (t == 1 || t == 2) begin                    // R4 dual rate classes
            m_mode = (t == 2) ? 3 : 2;
            if (t == 2 && rq >= sr / 2) begin          // R9
                m_hs = 1; m_div = 0; m_card = sr / 2;
            end else if (rq >= q) begin                // R7
                m_div = 0; m_card = q;
            end else begin                             // R8, R10
                if (rq == 0) k = 255;
                else begin
                    k = 1;
                    while (2 * k * rq < q && k < 256) k++;
                end
                if (k > 255) k = 255;
                m_div = int'(k); m_card = q / (2 * k);
            end
        end else if (rq >= sr) begin                   // R5
            m_mode = 1; m_div = 0; m_card = sr;
        end else begin                                 // R6, R10
            m_mode = 0;
            if (rq == 0) k = 255;
            else begin
                k = 1;
                while (k * rq < q && k < 256) k++;
            end
            if (k > 255) k = 255;
            m_div = int'(k); m_card = q / k;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_mode = 0; m_div = 0; m_hs = 0; m_card = 0; m_done = 0;
        end else if (m_busy) begin
            predict(m_tim, m_req, m_src);
            m_done = 1; m_busy = 0;
        end else begin
            m_done = 0;
            if (load_i) begin
                m_tim = timing_i; m_req = req_hz_i; m_src = src_hz_i;
                m_hs = 0; m_busy = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            n_cmp++;
            if (mode_o != m_mode[1:0] || div_o != m_div[7:0] || hs_ck_o != m_hs ||
                card_hz_o != m_card[31:0] || done_o != m_done) begin
                n_bad++;
                $display("FAIL %s: got mode=%0d div=%0d hs=%0b card=%0d done=%0b, expected mode=%0d div=%0d hs=%0b card=%0d done=%0b",
                         tag, mode_o, div_o, hs_ck_o, card_hz_o, done_o,
                         m_mode, m_div, m_hs, m_card, m_done);
            end
        end
    end

    task automatic select(input string t_name, input logic [1:0] t,
                          input logic [31:0] rq, input logic [31:0] sr);
        tag = t_name;
        @(negedge clk);
        timing_i = t; req_hz_i = rq; src_hz_i = sr; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        select("R5",  2'd0, 32'd200_000_000, 32'd200_000_000);
        select("R6",  2'd0, 32'd25_000_000,  32'd200_000_000);  // n=2
        select("R6",  2'd0, 32'd7_000_000,   32'd200_000_000);  // odd quotient
        select("R10", 2'd0, 32'd0,           32'd200_000_000);
        select("R4",  2'd3, 32'd400_000_000, 32'd200_000_000);  // reserved = single rate
        select("R6",  2'd0, 32'd1,           32'd3);            // Q=0, n=1
        select("R7",  2'd1, 32'd100_000_000, 32'd400_000_000);
        select("R8",  2'd1, 32'd20_000_000,  32'd400_000_000);  // k=3
        select("R8",  2'd1, 32'd25_000_000,  32'd400_000_000);  // exact k=2
        select("R10", 2'd1, 32'd1,           32'd400_000_000);
        select("R9",  2'd2, 32'd200_000_000, 32'd400_000_000);
        select("R2",  2'd1, 32'd50_000_000,  32'd400_000_000);  // flag cleared
        select("R9",  2'd2, 32'd210_000_000, 32'd400_000_000);
        select("R7",  2'd2, 32'd150_000_000, 32'd400_000_000);
        select("R8",  2'd2, 32'd10_000_000,  32'd400_000_000);
        // R3: load held two cycles and inputs changed during EVAL
        tag = "R3";
        @(negedge clk);
        timing_i = 2'd1; req_hz_i = 32'd30_000_000; src_hz_i = 32'd400_000_000; load_i = 1'b1;
        @(negedge clk);
        timing_i = 2'd2; req_hz_i = 32'd300_000_000;
        @(negedge clk);
        load_i = 1'b0;
        repeat (4) @(negedge clk);
        // R11: inputs wiggle without load
        tag = "R11";
        timing_i = 2'd0; req_hz_i = 32'd5; src_hz_i = 32'd9;
        repeat (4) @(negedge clk);
        // R1: reset again
        tag = "R1";
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL R2: watchdog expired, got no end, expected end of run");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule